// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block is a 16-bit interval timer that counts down on a divided copy of the system clock. It raises a sticky event flag each time the count passes from one to zero, and it drives an interrupt line whenever that flag is set and interrupts are enabled. Software programs it through three 16-bit registers on a simple synchronous write bus with an asynchronous read path. The registers are a control/status word, a modulus and the live count.

Each counting step takes 2^(p+1) clock cycles, where p is a 4-bit prescale exponent (0 to 15). In reload mode, the step after zero loads the modulus. In free-running mode, that step loads 0xFFFF. An overwrite option lets a modulus write go straight into the running counter. Writing a control word that differs from the stored one only in the interrupt-enable bit, or only asks for a flag clear, does not disturb the count. Two low-power/debug bits are stored and read back, but they have no effect on counting.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and the interrupt line is low.
- R2: Register offsets are 0 (control), 2 (modulus) and 4 (count). Control bits are: 0 run enable, 1 reload mode, 2 event flag, 3 interrupt enable, 4 overwrite, 5 debug, 6 doze, and 11:8 prescale exponent. Bits 7 and 15:12 read as zero, and an unmapped offset reads zero. The debug and doze bits read back as written and do not change the count timing.
- R3: Once a control write that changes the configuration has taken effect with run enable set, the counter decrements once every 2^(p+1) cycles. In reload mode with modulus M, the flag first sets M·2^(p+1) cycles after that write edge.
- R4: In reload mode, the step after the count reaches zero loads the modulus. Later flags therefore follow every (M+1)·2^(p+1) cycles.
- R5: In free-running mode, the step after zero loads 0xFFFF, and a configuring control write loads 0xFFFF.
- R6: Writing 1 to control bit 2 clears the flag. Writing 0 to it has no effect. If an expiry and a clear happen in the same cycle, the flag stays set.
- R7: The interrupt line is high exactly when the flag and the interrupt enable are both set. Clearing the enable hides a pending flag without losing it.
- R8: Any write to the modulus register clears the flag.
- R9: With overwrite set, a modulus write loads the written value into the count on that edge. With overwrite clear, the count continues, and the new modulus is used at the next reload.
- R10: A control write that changes the stored configuration reloads the count from the new limit and restarts the prescaler phase. A write that changes only the interrupt enable, or the flag, leaves the count and the phase untouched.
- R11: While run enable is clear, the count and the prescaler phase hold.
- R12: Writes to offset 4 or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
On every cycle, the embedded assertions check the following:
- an expiry always leaves the flag set;
- a modulus write without a coincident expiry leaves it clear;
- the count steps to zero from one and then loads the reload value;
- the count is frozen while the timer is disabled and the bus is idle;
- prescaler ticks are never back to back.

Only the bench scenarios can show the following:
- the absolute interrupt timing for several prescale exponents;
- the difference between overwrite and deferred modulus updates;
- the priority of an expiry over a same-cycle clear;
- whether a control write that changes only the interrupt enable leaves the count undisturbed.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Register data width and prescale exponent width are fixed by the layout.
    localparam int REG_W = 16;
    localparam int EXP_W = 4;

    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_MOD  = 3'd2;
    localparam logic [2:0] OFS_CNT  = 3'd4;

    // Control/status word, MSB first.
    typedef struct packed {
        logic [3:0]       rsv_hi;
        logic [EXP_W-1:0] pre_exp;
        logic             rsv7;
        logic             doze;
        logic             dbg;
        logic             ovw;
        logic             ie;
        logic             flag;
        logic             rld;
        logic             en;
    } ctrl_t;

    // Configuration fields whose change forces a counter restart.
    function automatic logic [EXP_W+4:0] cfg_bits(input ctrl_t c);
        return {c.pre_exp, c.doze, c.dbg, c.ovw, c.rld, c.en};
    endfunction

    // Strip reserved bits from a raw write.
    function automatic ctrl_t ctrl_clean(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c        = ctrl_t'(raw);
        c.rsv_hi = '0;
        c.rsv7   = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
#(
    parameter int XW = EXP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          clr_i,
    input  logic [XW-1:0] exp_i,
    output logic          tick_o
);
    localparam int PS_W = 1 << XW;

    logic [PS_W-1:0] phase_q;
    logic [PS_W:0]   span_wide;
    logic [PS_W-1:0] span;

    // Last phase index of a period of 2^(exp+1) cycles.
    always_comb begin
        span_wide = ({{PS_W{1'b0}}, 1'b1} << ({1'b0, exp_i} + (XW+1)'(1)))
                    - (PS_W+1)'(1);
        span      = span_wide[PS_W-1:0];
    end

    assign tick_o = run_i && (phase_q == span);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            phase_q <= '0;
        end else if (run_i) begin
            phase_q <= tick_o ? '0 : phase_q + PS_W'(1);
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R3

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt_o    = cnt_q;
    assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == '0) ? reload_val_i : cnt_q - CNT_W'(1);
        end
    end

    AST_STEP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cnt_q == CNT_W'(1)) |=> (cnt_q == '0)); // R3

    AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cnt_q == '0) |=> (cnt_q == $past(reload_val_i))); // R4

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_o
);
    ctrl_t            ctrl_q;
    ctrl_t            wv;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] reload_val;
    logic             wr_ctrl, wr_mod;
    logic             restart, ovw_load, flag_clr;
    logic             tick, expire;

    always_comb begin
        wv       = ctrl_clean(bus_wdata);
        wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
        wr_mod   = bus_wr && (bus_addr == OFS_MOD);
        restart  = wr_ctrl && (cfg_bits(wv) != cfg_bits(ctrl_q));
        ovw_load = wr_mod && ctrl_q.ovw;
        flag_clr = (wr_ctrl && wv.flag) || wr_mod;
        if (restart) begin
            load_val = wv.rld ? mod_q : '1;
        end else begin
            load_val = bus_wdata[CNT_W-1:0];
        end
        reload_val = ctrl_q.rld ? mod_q : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mod_q  <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ie <= wv.ie;
                if (restart) begin
                    ctrl_q.en      <= wv.en;
                    ctrl_q.rld     <= wv.rld;
                    ctrl_q.ovw     <= wv.ovw;
                    ctrl_q.dbg     <= wv.dbg;
                    ctrl_q.doze    <= wv.doze;
                    ctrl_q.pre_exp <= wv.pre_exp;
                end
            end
            if (wr_mod) begin
                mod_q <= bus_wdata[CNT_W-1:0];
            end
            // Expiry outranks a coincident clear.
            ctrl_q.flag <= expire || (ctrl_q.flag && !flag_clr);
        end
    end

    pit_prescaler #(.XW(EXP_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ctrl_q.en),
        .clr_i  (restart),
        .exp_i  (ctrl_q.pre_exp),
        .tick_o (tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick),
        .load_i       (restart || ovw_load),
        .load_val_i   (load_val),
        .reload_val_i (reload_val),
        .cnt_o        (cnt_w),
        .expire_o     (expire)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = REG_W'(ctrl_q);
            OFS_MOD:  bus_rdata = REG_W'(mod_q);
            OFS_CNT:  bus_rdata = REG_W'(cnt_w);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_o = ctrl_q.ie & ctrl_q.flag;

    AST_EXPIRY_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        expire |=> ctrl_q.flag); // R6

    AST_MOD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_mod && !expire) |=> !ctrl_q.flag); // R8

    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !bus_wr) |=> $stable(cnt_w)); // R11

endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int total = 0;
    int passed = 0;
    int cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pit_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // {prescale exponent, modulus}
    localparam logic [19:0] VEC [0:5] = '{
        {4'd0, 16'd5}, {4'd1, 16'd3}, {4'd2, 16'd4},
        {4'd3, 16'd2}, {4'd0, 16'd1}, {4'd5, 16'd3}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act == exp) passed++;
        else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        bus_addr = a; #1;
        v = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wait_irq(output int t);
        for (int i = 0; i < 20000; i++) begin
            if (irq_o) break;
            @(posedge clk); #1;
        end
        t = cyc;
    endtask

    initial begin
        #(20 * 150000);
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        int v, t0, t1, t2, ta;
        logic [15:0] cw;
        int per;

        // R1 reset state
        do_reset;
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd2, v); chk("R1 mod", v, 16'hFFFF);
        rd(3'd4, v); chk("R1 cnt", v, 16'hFFFF);
        chk("R1 irq", int'(irq_o), 0);

        // R2 readback, reserved bits and unmapped offset
        wr(3'd0, 16'hFFFA);
        rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0F7A);
        rd(3'd6, v); chk("R2 unmapped read", v, 0);

        // Table walk: R3 first expiry, R4 period, R6 clear; odd rows set dbg/doze (R2)
        for (int i = 0; i < 6; i++) begin
            logic [3:0]  pe;
            logic [15:0] m;
            {pe, m} = VEC[i];
            per = 1 << (int'(pe) + 1);
            do_reset;
            wr(3'd2, m);
            cw = 16'h000B | (16'(pe) << 8) | ((i % 2 == 1) ? 16'h0060 : 16'h0000);
            wr(3'd0, cw);
            t0 = cyc;
            wait_irq(t1);
            chk($sformatf("R3 first expiry row %0d", i), t1 - t0, int'(m) * per);
            wr(3'd0, cw | 16'h0004);
            chk($sformatf("R6 clear row %0d", i), int'(irq_o), 0);
            wait_irq(t2);
            chk($sformatf("R4 period row %0d", i), t2 - t0, (2 * int'(m) + 1) * per);
        end

        // R5 free-running rollover with overwrite into a running counter
        do_reset;
        wr(3'd0, 16'h0019);
        rd(3'd4, v); chk("R5 free load", v, 16'hFFFF);
        wr(3'd2, 16'd3);
        rd(3'd4, v); chk("R9 overwrite free", v, 3);
        idle(4); chk("R3 no early flag", int'(irq_o), 0);
        idle(1); chk("R5 expiry", int'(irq_o), 1);
        idle(2); rd(3'd4, v); chk("R5 rollover", v, 16'hFFFF);

        // R10 interrupt-enable-only write leaves count running
        do_reset;
        wr(3'd2, 16'd100);
        wr(3'd0, 16'h0003);
        idle(9);
        wr(3'd0, 16'h000B);
        rd(3'd4, v); chk("R10 ie-only no restart", v, 95);
        wr(3'd0, 16'h010B);
        rd(3'd4, v); chk("R10 cfg change restarts", v, 100);
        idle(3); rd(3'd4, v); chk("R10 phase restarted", v, 100);
        idle(1); rd(3'd4, v); chk("R3 step at new rate", v, 99);

        // R9 overwrite versus deferred modulus
        do_reset;
        wr(3'd0, 16'h0013);
        wr(3'd2, 16'd7);
        rd(3'd4, v); chk("R9 overwrite reload mode", v, 7);
        wr(3'd0, 16'h000B);
        ta = cyc;
        idle(1);
        wr(3'd2, 16'd3);
        rd(3'd4, v); chk("R9 deferred count", v, 6);
        wait_irq(t1);
        chk("R9 old modulus expiry", t1 - ta, 14);
        idle(2); rd(3'd4, v); chk("R9 new modulus at reload", v, 3);

        // R6/R7/R8 flag handling
        do_reset;
        wr(3'd2, 16'd2);
        wr(3'd0, 16'h000B);
        idle(3); chk("R3 before expiry", int'(irq_o), 0);
        wr(3'd0, 16'h000F);
        chk("R6 set wins over clear", int'(irq_o), 1);
        wr(3'd0, 16'h000B);
        chk("R6 write zero keeps flag", int'(irq_o), 1);
        wr(3'd0, 16'h0003);
        chk("R7 ie off masks irq", int'(irq_o), 0);
        rd(3'd0, v); chk("R7 flag still pending", v, 16'h0007);
        wr(3'd0, 16'h000B);
        chk("R7 ie on shows irq", int'(irq_o), 1);
        wr(3'd0, 16'h000F);
        chk("R6 write one clears", int'(irq_o), 0);
        rd(3'd0, v); chk("R6 ctrl after clear", v, 16'h000B);
        idle(2); chk("R4 second expiry", int'(irq_o), 1);
        wr(3'd2, 16'd2);
        chk("R8 modulus write clears", int'(irq_o), 0);

        // R11 disabled hold, R12 ignored writes
        wr(3'd0, 16'h0002);
        rd(3'd4, v); chk("R11 count after disable", v, 2);
        idle(10); rd(3'd4, v); chk("R11 count holds", v, 2);
        wr(3'd4, 16'h1234);
        rd(3'd4, v); chk("R12 count write ignored", v, 2);
        wr(3'd6, 16'h5555);
        rd(3'd0, v); chk("R12 ctrl untouched", v, 16'h0002);
        rd(3'd2, v); chk("R12 mod untouched", v, 2);

        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

endmodule